// File: doc/BRIEF.md
# Single-Cycle Accumulator Execution Unit

This block carries out the one-byte register-to-register instructions of a small 8-bit processor, one instruction per clock. It owns a bank of eight 8-bit registers, of which register 0 serves as the accumulator, and an 8-bit status word. An instruction byte arrives with a valid strobe. Its upper five bits pick the operation. Its lower three bits name either a register or a bit position. The block updates its registers and its status word at the clock edge that samples the strobe. Both are visible on output ports at all times.

The status word places zero at bit 0, carry at bit 1, negative at bit 2 and interrupt enable at bit 3. Bits 7:4 are free for software. A set vector and a clear vector let surrounding logic force those four upper bits on every cycle, whether or not an instruction is present.

Top module: `acc_alu_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all eight registers and the whole status word to zero.
- R2: instr[7:3] selects the operation and instr[2:0] selects register n or bit n. When instr_valid is low the registers and status bits 3:0 do not change, and an instruction takes effect at the single rising edge that samples it.
- R3: ADD (0x50), add-with-carry (0x08) and subtract-with-borrow (0x48) write reg0 + regn, reg0 + regn + C, and reg0 - regn - C into reg0. N becomes result bit 7, Z is set when the 8-bit result is zero, and C becomes the ninth sum bit (the borrow for the subtract).
- R4: Increment (0x00) and decrement (0x40) update regn in place. N and Z follow the result, C is the carry out of the increment or the borrow of the decrement.
- R5: OR (0x18), AND (0x20) and XOR (0x28) combine reg0 with regn into reg0, update N and Z, and leave C unchanged.
- R6: Move-into-accumulator (0x10) copies regn into reg0 and move-out-of-accumulator (0x70) copies reg0 into regn. Both update N and Z and leave C unchanged.
- R7: Rotate left (0x30) makes regn = {regn[6:0], C} with the new C taken from regn[7]. Rotate right (0x38) makes regn = {C, regn[7:1]} with the new C taken from regn[0]. N and Z follow the result.
- R8: Compare (0x78) computes reg0 - regn, updates N, Z and C as a subtraction, and writes no register.
- R9: Bit test (0x60) sets Z when bit n of reg0 is 0 and clears Z when it is 1. All other status bits are left unchanged.
- R10: Bit set (0x58) sets status bit n and bit clear (0x68) clears status bit n. No other status bit changes.
- R11: ext_set[k] and ext_clr[k] act on status bit 4+k at every edge, regardless of instr_valid, and take precedence over the instruction's effect on that bit. When both are high, set wins.
- R12: Any instruction byte with bit 7 set (0x80 to 0xFF) changes no register and no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction byte present this cycle |
| instr | input | 8 | Instruction byte: operation in [7:3], register/bit in [2:0] |
| ext_set | input | 4 | Force status bits 7:4 to one |
| ext_clr | input | 4 | Force status bits 7:4 to zero |
| regs_flat | output | 64 | Register bank, register i at bits [8i+7:8i] |
| status | output | 8 | Status word |

## Verification
The whole architectural state (eight registers and the status word) is driven straight from flops onto the outputs. A wrong result, a write to the wrong register or a corrupted flag is therefore visible on the edge that executes the instruction, with no extra delay. Errors that show up later are errors in carry. A carry kept wrongly through a logical operation or a rotate only surfaces in a later add, subtract or rotate. For that reason the full state is compared after every instruction, not only the destination register.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   // status word bit positions
   localparam int ST_Z  = 0;
   localparam int ST_C  = 1;
   localparam int ST_N  = 2;
   localparam int ST_IE = 3;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_INCR     = 5'd0,
      OP_ADDC     = 5'd1,
      OP_MOVE_IN  = 5'd2,
      OP_OR       = 5'd3,
      OP_AND      = 5'd4,
      OP_XOR      = 5'd5,
      OP_ROTL     = 5'd6,
      OP_ROTR     = 5'd7,
      OP_DECR     = 5'd8,
      OP_SUBB     = 5'd9,
      OP_ADD      = 5'd10,
      OP_BSET     = 5'd11,
      OP_BTEST    = 5'd12,
      OP_BCLR     = 5'd13,
      OP_MOVE_OUT = 5'd14,
      OP_COMPARE  = 5'd15
   } op_e;

   typedef enum logic [2:0] {
      RES_SUM,
      RES_OR,
      RES_AND,
      RES_XOR,
      RES_SRC,
      RES_ACC,
      RES_ROTL,
      RES_ROTR
   } res_sel_e;

   typedef enum logic [1:0] {
      CI_ZERO,
      CI_ONE,
      CI_CARRY
   } cin_sel_e;

   typedef enum logic [1:0] {
      BOP_NONE,
      BOP_SET,
      BOP_CLR,
      BOP_TEST
   } bit_op_e;

   typedef struct packed {
      res_sel_e res;
      logic     a_is_acc;
      logic     b_zero;
      logic     sub;
      cin_sel_e cin;
      logic     wr;
      logic     wr_acc;
      logic     upd_nz;
      logic     upd_c;
      bit_op_e  bop;
   } ctl_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
   import acc_alu_pkg::*;
(
   input  logic [OP_W-1:0] op,
   output ctl_t            ctl,
   output logic            legal
);

   assign legal = ~op[OP_W-1];

   always_comb begin
      ctl          = '0;
      ctl.res      = RES_SUM;
      ctl.cin      = CI_ZERO;
      ctl.bop      = BOP_NONE;
      case (op)
         OP_INCR: begin
            ctl.b_zero = 1'b1;
            ctl.cin    = CI_ONE;
            ctl.wr     = 1'b1;
            ctl.upd_nz = 1'b1;
            ctl.upd_c  = 1'b1;
         end
         OP_ADDC: begin
            ctl.a_is_acc = 1'b1;
            ctl.cin      = CI_CARRY;
            ctl.wr       = 1'b1;
            ctl.wr_acc   = 1'b1;
            ctl.upd_nz   = 1'b1;
            ctl.upd_c    = 1'b1;
         end
         OP_MOVE_IN: begin
            ctl.res    = RES_SRC;
            ctl.wr     = 1'b1;
            ctl.wr_acc = 1'b1;
            ctl.upd_nz = 1'b1;
         end
         OP_OR: begin
            ctl.res    = RES_OR;
            ctl.wr     = 1'b1;
            ctl.wr_acc = 1'b1;
            ctl.upd_nz = 1'b1;
         end
         OP_AND: begin
            ctl.res    = RES_AND;
            ctl.wr     = 1'b1;
            ctl.wr_acc = 1'b1;
            ctl.upd_nz = 1'b1;
         end
         OP_XOR: begin
            ctl.res    = RES_XOR;
            ctl.wr     = 1'b1;
            ctl.wr_acc = 1'b1;
            ctl.upd_nz = 1'b1;
         end
         OP_ROTL: begin
            ctl.res    = RES_ROTL;
            ctl.wr     = 1'b1;
            ctl.upd_nz = 1'b1;
            ctl.upd_c  = 1'b1;
         end
         OP_ROTR: begin
            ctl.res    = RES_ROTR;
            ctl.wr     = 1'b1;
            ctl.upd_nz = 1'b1;
            ctl.upd_c  = 1'b1;
         end
         OP_DECR: begin
            ctl.b_zero = 1'b1;
            ctl.sub    = 1'b1;
            ctl.cin    = CI_ONE;
            ctl.wr     = 1'b1;
            ctl.upd_nz = 1'b1;
            ctl.upd_c  = 1'b1;
         end
         OP_SUBB: begin
            ctl.a_is_acc = 1'b1;
            ctl.sub      = 1'b1;
            ctl.cin      = CI_CARRY;
            ctl.wr       = 1'b1;
            ctl.wr_acc   = 1'b1;
            ctl.upd_nz   = 1'b1;
            ctl.upd_c    = 1'b1;
         end
         OP_ADD: begin
            ctl.a_is_acc = 1'b1;
            ctl.wr       = 1'b1;
            ctl.wr_acc   = 1'b1;
            ctl.upd_nz   = 1'b1;
            ctl.upd_c    = 1'b1;
         end
         OP_BSET:  ctl.bop = BOP_SET;
         OP_BTEST: ctl.bop = BOP_TEST;
         OP_BCLR:  ctl.bop = BOP_CLR;
         OP_MOVE_OUT: begin
            ctl.res    = RES_ACC;
            ctl.wr     = 1'b1;
            ctl.upd_nz = 1'b1;
         end
         OP_COMPARE: begin
            ctl.a_is_acc = 1'b1;
            ctl.sub      = 1'b1;
            ctl.upd_nz   = 1'b1;
            ctl.upd_c    = 1'b1;
         end
         default: ctl.bop = BOP_NONE;
      endcase
   end

endmodule

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         ci,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         co
);

   // add: sum = a + b + ci, co = carry out
   // sub: sum = a - b - ci, co = borrow out
   if (RIPPLE) begin : g_ripple
      logic [W:0]   c;
      logic [W-1:0] bx;
      assign bx   = sub ? ~b : b;
      assign c[0] = sub ? ~ci : ci;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum[i]  = a[i] ^ bx[i] ^ c[i];
         assign c[i+1]  = (a[i] & bx[i]) | (c[i] & (a[i] ^ bx[i]));
      end
      assign co = sub ? ~c[W] : c[W];
   end else begin : g_flat
      logic [W:0] t;
      logic [W:0] ce;
      assign ce = {{W{1'b0}}, ci};
      assign t  = sub ? ({1'b0, a} - {1'b0, b} - ce)
                      : ({1'b0, a} + {1'b0, b} + ce);
      assign sum = t[W-1:0];
      assign co  = t[W];
   end

endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3,
   parameter bit RIPPLE = 1'b0
) (
   input  ctl_t              ctl,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] st,
   input  logic [SEL_W-1:0]  bsel,
   output logic [DATA_W-1:0] res,
   output logic [DATA_W-1:0] st_next
);

   logic [DATA_W-1:0] add_a;
   logic [DATA_W-1:0] add_b;
   logic [DATA_W-1:0] add_sum;
   logic              add_ci;
   logic              add_co;
   logic              c_new;
   logic              c_old;

   assign c_old = st[ST_C];
   assign add_a = ctl.a_is_acc ? acc : src;
   assign add_b = ctl.b_zero ? '0 : src;

   always_comb begin
      case (ctl.cin)
         CI_ONE:   add_ci = 1'b1;
         CI_CARRY: add_ci = c_old;
         default:  add_ci = 1'b0;
      endcase
   end

   acc_alu_adder #(.W(DATA_W), .RIPPLE(RIPPLE)) i_adder (
      .a   (add_a),
      .b   (add_b),
      .ci  (add_ci),
      .sub (ctl.sub),
      .sum (add_sum),
      .co  (add_co)
   );

   always_comb begin
      c_new = add_co;
      case (ctl.res)
         RES_OR:   res = acc | src;
         RES_AND:  res = acc & src;
         RES_XOR:  res = acc ^ src;
         RES_SRC:  res = src;
         RES_ACC:  res = acc;
         RES_ROTL: begin
            res   = {src[DATA_W-2:0], c_old};
            c_new = src[DATA_W-1];
         end
         RES_ROTR: begin
            res   = {c_old, src[DATA_W-1:1]};
            c_new = src[0];
         end
         default:  res = add_sum;
      endcase
   end

   always_comb begin
      st_next = st;
      if (ctl.upd_nz) begin
         st_next[ST_N] = res[DATA_W-1];
         st_next[ST_Z] = (res == '0);
      end
      if (ctl.upd_c) begin
         st_next[ST_C] = c_new;
      end
      case (ctl.bop)
         BOP_SET:  st_next[bsel]  = 1'b1;
         BOP_CLR:  st_next[bsel]  = 1'b0;
         BOP_TEST: st_next[ST_Z]  = ~acc[bsel];
         default:  st_next[ST_Z]  = st_next[ST_Z];
      endcase
   end

endmodule

// File: rtl/acc_alu_regbank.sv
module acc_alu_regbank #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      we,
   input  logic [SEL_W-1:0]          waddr,
   input  logic [DATA_W-1:0]         wdata,
   input  logic [SEL_W-1:0]          raddr,
   output logic [DATA_W-1:0]         rdata,
   output logic [DATA_W-1:0]         racc,
   output logic [(DATA_W<<SEL_W)-1:0] flat
);

   localparam int NREGS = 1 << SEL_W;

   logic [DATA_W-1:0] q [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            q[i] <= '0;
         end else if (we && (waddr == SEL_W'(i))) begin
            q[i] <= wdata;
         end
      end
      assign flat[i*DATA_W +: DATA_W] = q[i];
   end

   assign rdata = q[raddr];
   assign racc  = q[0];

endmodule

// File: rtl/acc_alu_status.sv
module acc_alu_status #(
   parameter int DATA_W = 8,
   parameter int EXT_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              upd,
   input  logic [DATA_W-1:0] st_in,
   input  logic [EXT_W-1:0]  ext_set,
   input  logic [EXT_W-1:0]  ext_clr,
   output logic [DATA_W-1:0] st
);

   localparam int HI = DATA_W - 1;

   logic [DATA_W-1:0] base;
   logic [DATA_W-1:0] nxt;

   always_comb begin
      base            = upd ? st_in : st;
      nxt             = base;
      nxt[HI -: EXT_W] = (base[HI -: EXT_W] & ~ext_clr) | ext_set;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st <= '0;
      end else begin
         st <= nxt;
      end
   end

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3,
   parameter int EXT_W  = 4,
   parameter bit RIPPLE = 1'b0,
   localparam int INSTR_W = OP_W + SEL_W,
   localparam int FLAT_W  = DATA_W << SEL_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr,
   input  logic [EXT_W-1:0]   ext_set,
   input  logic [EXT_W-1:0]   ext_clr,
   output logic [FLAT_W-1:0]  regs_flat,
   output logic [DATA_W-1:0]  status
);

   if (DATA_W != (1 << SEL_W)) begin : g_bad_sel
      $error("DATA_W must equal 2**SEL_W so a bit field covers the word");
   end
   if (EXT_W < 1 || EXT_W > DATA_W - 4) begin : g_bad_ext
      $error("EXT_W must fit above the four flag bits");
   end

   ctl_t              ctl;
   logic              legal;
   logic              exec;
   logic [SEL_W-1:0]  sel;
   logic [DATA_W-1:0] src;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] res;
   logic [DATA_W-1:0] st_next;
   logic [SEL_W-1:0]  waddr;

   assign sel   = instr[SEL_W-1:0];
   assign exec  = instr_valid & legal;
   assign waddr = ctl.wr_acc ? '0 : sel;

   acc_alu_decode i_decode (
      .op    (instr[INSTR_W-1:SEL_W]),
      .ctl   (ctl),
      .legal (legal)
   );

   acc_alu_regbank #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_regbank (
      .clk   (clk),
      .rst   (rst),
      .we    (exec & ctl.wr),
      .waddr (waddr),
      .wdata (res),
      .raddr (sel),
      .rdata (src),
      .racc  (acc),
      .flat  (regs_flat)
   );

   acc_alu_datapath #(.DATA_W(DATA_W), .SEL_W(SEL_W), .RIPPLE(RIPPLE)) i_datapath (
      .ctl     (ctl),
      .acc     (acc),
      .src     (src),
      .st      (status),
      .bsel    (sel),
      .res     (res),
      .st_next (st_next)
   );

   acc_alu_status #(.DATA_W(DATA_W), .EXT_W(EXT_W)) i_status (
      .clk     (clk),
      .rst     (rst),
      .upd     (exec),
      .st_in   (st_next),
      .ext_set (ext_set),
      .ext_clr (ext_clr),
      .st      (status)
   );

endmodule

// File: rtl/acc_alu_unit_chk.sv
module acc_alu_unit_chk #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3,
   parameter int EXT_W  = 4,
   localparam int INSTR_W = 5 + SEL_W,
   localparam int FLAT_W  = DATA_W << SEL_W,
   localparam int HI      = DATA_W - 1
) (
   input logic               clk,
   input logic               rst,
   input logic               instr_valid,
   input logic [INSTR_W-1:0] instr,
   input logic [EXT_W-1:0]   ext_set,
   input logic [EXT_W-1:0]   ext_clr,
   input logic [FLAT_W-1:0]  regs_flat,
   input logic [DATA_W-1:0]  status
);

   logic [4:0] op;
   logic       no_ext;
   assign op     = instr[INSTR_W-1:SEL_W];
   assign no_ext = (ext_set == '0) && (ext_clr == '0);

   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (regs_flat == '0) && (status == '0)); // R1

   AST_IDLE_HOLDS_REGS: assert property (@(posedge clk) disable iff (rst)
      !instr_valid |=> $stable(regs_flat) && $stable(status[3:0])); // R2

   AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
      instr_valid && (op >= 5'd2) && (op <= 5'd5) |=> $stable(status[1])); // R5

   AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      instr_valid && (op == 5'd15) |=> $stable(regs_flat)); // R8

   AST_BTEST_ZERO: assert property (@(posedge clk) disable iff (rst)
      instr_valid && (op == 5'd12) |=>
         (status[0] == !$past(regs_flat[instr[SEL_W-1:0]]))); // R9

   AST_BSET_LOW_BIT: assert property (@(posedge clk) disable iff (rst)
      instr_valid && (op == 5'd11) && !instr[SEL_W-1] |=>
         status[$past(instr[SEL_W-1:0])]); // R10

   AST_EXT_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      (ext_set != '0) |=>
         ((status[HI -: EXT_W] & $past(ext_set)) == $past(ext_set))); // R11

   AST_EXT_CLEAR: assert property (@(posedge clk) disable iff (rst)
      ((ext_clr & ~ext_set) != '0) |=>
         ((status[HI -: EXT_W] & $past(ext_clr & ~ext_set)) == '0)); // R11

   AST_HIGH_OPS_INERT: assert property (@(posedge clk) disable iff (rst)
      instr_valid && instr[INSTR_W-1] && no_ext |=>
         $stable(regs_flat) && $stable(status)); // R12

endmodule

bind acc_alu_unit acc_alu_unit_chk #(
   .DATA_W (DATA_W),
   .SEL_W  (SEL_W),
   .EXT_W  (EXT_W)
) i_chk (
   .clk         (clk),
   .rst         (rst),
   .instr_valid (instr_valid),
   .instr       (instr),
   .ext_set     (ext_set),
   .ext_clr     (ext_clr),
   .regs_flat   (regs_flat),
   .status      (status)
);

// File: tb/test_acc_alu_unit.sv
module test_acc_alu_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        instr_valid = 1'b0;
   logic [7:0]  instr = 8'h00;
   logic [3:0]  ext_set = 4'h0;
   logic [3:0]  ext_clr = 4'h0;
   logic [63:0] regs_flat;
   logic [7:0]  status;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   logic [7:0] m_r [8];
   logic [7:0] m_st;

   always #10 clk = ~clk;

   acc_alu_unit i_acc_alu_unit (
      .clk         (clk),
      .rst         (rst),
      .instr_valid (instr_valid),
      .instr       (instr),
      .ext_set     (ext_set),
      .ext_clr     (ext_clr),
      .regs_flat   (regs_flat),
      .status      (status)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         errors++;
         $display("FAIL watchdog R2 act cycles=%0d exp below 60000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic string tag_of(input logic [7:0] ins, input logic v);
      if (!v) return "R2";
      if (ins[7]) return "R12";
      case (ins[6:3])
         4'd0, 4'd8:         return "R4";
         4'd1, 4'd9, 4'd10:  return "R3";
         4'd2, 4'd14:        return "R6";
         4'd3, 4'd4, 4'd5:   return "R5";
         4'd6, 4'd7:         return "R7";
         4'd11, 4'd13:       return "R10";
         4'd12:              return "R9";
         default:            return "R8";
      endcase
   endfunction

   function automatic logic [63:0] m_flat();
      logic [63:0] f;
      for (int i = 0; i < 8; i++) f[i*8 +: 8] = m_r[i];
      return f;
   endfunction

   task automatic m_flags(input logic [7:0] r, input logic c, input logic do_c);
      m_st[2] = r[7];
      m_st[0] = (r == 8'h00);
      if (do_c) m_st[1] = c;
   endtask

   task automatic model(input logic [7:0] ins, input logic v,
                        input logic [3:0] s, input logic [3:0] c);
      logic [7:0] a, b, r;
      logic [8:0] t;
      logic       cf;
      int         n;
      n  = int'(ins[2:0]);
      a  = m_r[0];
      b  = m_r[n];
      cf = m_st[1];
      if (v && !ins[7]) begin
         case (ins[6:3])
            4'd0:  begin t = {1'b0, b} + 9'd1; m_r[n] = t[7:0]; m_flags(t[7:0], t[8], 1'b1); end
            4'd1:  begin t = {1'b0, a} + {1'b0, b} + {8'd0, cf}; m_r[0] = t[7:0]; m_flags(t[7:0], t[8], 1'b1); end
            4'd2:  begin m_r[0] = b; m_flags(b, 1'b0, 1'b0); end
            4'd3:  begin r = a | b; m_r[0] = r; m_flags(r, 1'b0, 1'b0); end
            4'd4:  begin r = a & b; m_r[0] = r; m_flags(r, 1'b0, 1'b0); end
            4'd5:  begin r = a ^ b; m_r[0] = r; m_flags(r, 1'b0, 1'b0); end
            4'd6:  begin r = {b[6:0], cf}; m_r[n] = r; m_flags(r, b[7], 1'b1); end
            4'd7:  begin r = {cf, b[7:1]}; m_r[n] = r; m_flags(r, b[0], 1'b1); end
            4'd8:  begin t = {1'b0, b} - 9'd1; m_r[n] = t[7:0]; m_flags(t[7:0], t[8], 1'b1); end
            4'd9:  begin t = {1'b0, a} - {1'b0, b} - {8'd0, cf}; m_r[0] = t[7:0]; m_flags(t[7:0], t[8], 1'b1); end
            4'd10: begin t = {1'b0, a} + {1'b0, b}; m_r[0] = t[7:0]; m_flags(t[7:0], t[8], 1'b1); end
            4'd11: m_st[n] = 1'b1;
            4'd12: m_st[0] = ~a[n];
            4'd13: m_st[n] = 1'b0;
            4'd14: begin m_r[n] = a; m_flags(a, 1'b0, 1'b0); end
            default: begin t = {1'b0, a} - {1'b0, b}; m_flags(t[7:0], t[8], 1'b1); end
         endcase
      end
      m_st[7:4] = (m_st[7:4] & ~c) | s;
   endtask

   task automatic compare(input string tag, input logic ext_used);
      checks++;
      if (regs_flat !== m_flat()) begin
         errors++;
         $display("FAIL %s regs act %h exp %h", tag, regs_flat, m_flat());
      end
      checks++;
      if (status !== m_st) begin
         errors++;
         $display("FAIL %s status act %h exp %h", tag, status, m_st);
      end
      if (ext_used) begin
         checks++;
         if (status[7:4] !== m_st[7:4]) begin
            errors++;
            $display("FAIL R11 upper status act %h exp %h", status[7:4], m_st[7:4]);
         end
      end
   endtask

   task automatic step(input logic [7:0] ins, input logic v,
                       input logic [3:0] s, input logic [3:0] c);
      @(negedge clk);
      instr = ins; instr_valid = v; ext_set = s; ext_clr = c;
      @(posedge clk);
      model(ins, v, s, c);
      #2;
      compare(tag_of(ins, v), (s | c) != 4'h0);
   endtask

   task automatic op(input logic [7:0] ins);
      step(ins, 1'b1, 4'h0, 4'h0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; instr = 8'h50; instr_valid = 1'b1; ext_set = 4'hF; ext_clr = 4'h0;
      repeat (3) @(posedge clk);
      #2;
      for (int i = 0; i < 8; i++) m_r[i] = 8'h00;
      m_st = 8'h00;
      checks++;
      if (regs_flat !== 64'h0 || status !== 8'h00) begin
         errors++;
         $display("FAIL R1 reset act %h/%h exp 0/0", regs_flat, status);
      end
      @(negedge clk);
      rst = 1'b0; instr_valid = 1'b0; ext_set = 4'h0;
   endtask

   // accumulator := v, by clearing and counting up
   task automatic load_acc(input logic [7:0] v);
      op(8'h28);
      for (int k = 0; k < int'(v); k++) op(8'h00);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      do_reset();

      // R2: strobe low, increment of reg1 must not land
      step(8'h01, 1'b0, 4'h0, 4'h0);
      // R4: increment reg1 to 1, decrement reg2 from 0 to FF with borrow
      op(8'h01);
      op(8'h42);
      // R3: FF + 1 wraps to zero with carry out
      load_acc(8'hFF);
      op(8'h51);
      // R3: 0 - 1 - carry gives FE with borrow
      op(8'h49);
      // R6: copy accumulator to reg4, then back
      op(8'h74);
      op(8'h14);
      // R8: equal compare sets Z, clears C, writes nothing
      op(8'h7C);
      // R7: rotates through carry on reg4
      op(8'h34);
      op(8'h3C);
      op(8'h34);
      // R5: carry held through OR, AND, XOR
      op(8'h1A);
      op(8'h24);
      op(8'h2B);
      // R9: test bits 0 and 1 of the accumulator
      op(8'h60);
      op(8'h61);
      // R10: set and clear status bits
      op(8'h5D);
      op(8'h5B);
      op(8'h69);
      op(8'h6B);
      // R11: set and clear together, set wins; clear beats bit set instruction
      step(8'h00, 1'b0, 4'b0100, 4'b0100);
      step(8'h5D, 1'b1, 4'h0, 4'b0010);
      step(8'h5F, 1'b1, 4'b0001, 4'b1000);
      // R12: high opcodes have no effect
      op(8'h80);
      op(8'hB9);
      op(8'hFF);

      for (int i = 0; i < 3000; i++) begin
         logic [7:0] ins;
         logic       v;
         logic [3:0] s, c;
         ins = 8'($urandom);
         if (($urandom % 6) != 0) ins[7] = 1'b0;
         v = (($urandom % 8) != 0);
         s = 4'h0;
         c = 4'h0;
         if (($urandom % 6) == 0) begin
            s = 4'($urandom);
            c = 4'($urandom);
         end
         step(ins, v, s, c);
      end

      do_reset();
      op(8'h45);
      op(8'h55);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule